// File: doc/BRIEF.md
# Supply supervisor with ramp watchdog

This block holds a system in reset whenever a sampled supply-voltage code is too low, and keeps it there for a fixed hold time after the supply comes back. Once released, it watches a heartbeat input from the system. The heartbeat must show falling edges often enough, or the block raises a watchdog reset.

The timing element is a virtual capacitor: an up/down counter that charges by a large step and discharges by a small step. The counter is cleared while the supply is low. It charges from zero to its top limit to time the hold. After release it discharges. A heartbeat falling edge during discharge turns the counter around to charge back up to the top. If the counter drains down to its floor, reset is asserted while it charges back up to the top. The timeout therefore lies between the drain time and the drain time plus the refill time.

A forced-reset input and a watchdog-inhibit input adjust this behaviour. The reset is given as two registered outputs of opposite polarity.

Top module: `supply_watchdog_sup`

## Requirements
- R1: During `rst_n` low, `rst_hi` is 1 and `rst_lo` is 0. On every cycle `rst_lo` is the inverse of `rst_hi`, and both change only on a clock edge.
- R2: The supply detector has hysteresis. A supply that is not yet good becomes good only at a code of at least RISE_CODE (default 172). A good supply becomes bad only at a code below FALL_CODE (default 168). A code between the two leaves the current state unchanged.
- R3: At the first edge that samples a supply code below FALL_CODE, `rst_hi` rises at that edge and the counter is cleared to 0. This applies in every phase, including while the watchdog is inhibited.
- R4: After the supply becomes good, reset stays asserted for one edge plus CAP_TOP/CHG_STEP charging edges (21 edges by default). Heartbeat edges do not change this count.
- R5: After release, the counter drops by DIS_STEP per edge. With no heartbeat, reset asserts at the edge where the counter reaches CAP_FLOOR, which is 80 edges by default. Reset then lasts (CAP_TOP−CAP_FLOOR)/CHG_STEP edges, which is 16 by default, before it releases again. The counter never exceeds CAP_TOP.
- R6: The heartbeat passes through a two-flop synchroniser. A 1-to-0 transition seen during discharge turns the counter to charging, and reaching CAP_TOP returns it to discharge. Heartbeats that come well within the drain time keep reset deasserted indefinitely. Rising edges do nothing.
- R7: While `wd_inhibit` is 1 in the released state, the counter does not move and no watchdog reset occurs.
- R8: While `force_rst` is 1 and the supply is good, the counter is held at 0 and reset is asserted at the next edge. After `force_rst` falls, reset releases after CAP_TOP/CHG_STEP edges (20 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| supply_code | input | SUP_W (8) | Sampled supply-voltage code |
| heartbeat | input | 1 | Asynchronous heartbeat; its falling edges feed the watchdog |
| force_rst | input | 1 | Holds reset asserted while 1 |
| wd_inhibit | input | 1 | Freezes the watchdog counter while 1 |
| rst_hi | output | 1 | Active-high reset, registered |
| rst_lo | output | 1 | Active-low reset, registered, always the inverse of `rst_hi` |

## Verification
The supply code is stepped through several levels: below the fall threshold, inside the hysteresis band from both directions, and above the rise threshold. These separate a detector with hysteresis from one with a single threshold. Heartbeat patterns cover none at all, sparse pulses well inside the drain time, and a toggle on every cycle during the hold. Together they separate a hold that ignores edges from one that restarts on them, and a watchdog that drains fully from one that reloads. Exact edge counts are measured for the supply hold, the forced hold, the drain and the refill, so a counter that is off by one step is exposed. The inhibit run and the supply drop inside it show whether the freeze blocks only the watchdog or the supply path as well.

// File: rtl/swd_pkg.sv
package swd_pkg;

  // Phases of the virtual timing capacitor
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,  // supply bad, counter cleared
    PH_HOLD  = 3'd1,  // power-up or forced hold, charging
    PH_DRAIN = 3'd2,  // released, discharging
    PH_FILL  = 3'd3,  // released, charging after heartbeat
    PH_BITE  = 3'd4   // watchdog reset, charging back to top
  } phase_t;

  // Charge step, saturating at the top limit
  function automatic int unsigned ramp_up(input int unsigned c,
                                          input int unsigned step,
                                          input int unsigned top);
    return (c + step >= top) ? top : c + step;
  endfunction

  // Discharge step, saturating at the floor
  function automatic int unsigned ramp_down(input int unsigned c,
                                            input int unsigned step,
                                            input int unsigned floor_v);
    return (c <= floor_v + step) ? floor_v : c - step;
  endfunction

  // Reset is asserted in every phase except the two released ones
  function automatic logic phase_in_reset(input phase_t p);
    return !(p == PH_DRAIN || p == PH_FILL);
  endfunction

endpackage

// File: rtl/swd_level_det.sv
module swd_level_det #(
  parameter int unsigned SUP_W     = 8,
  parameter int unsigned RISE_CODE = 172,
  parameter int unsigned FALL_CODE = 168
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] code,
  output logic             ok_nx,
  output logic             ok_q
);
  localparam logic [SUP_W-1:0] RISE_C = SUP_W'(RISE_CODE);
  localparam logic [SUP_W-1:0] FALL_C = SUP_W'(FALL_CODE);

  // Hysteresis: the threshold that applies depends on the current state
  always_comb begin
    if (ok_q) ok_nx = (code >= FALL_C);
    else      ok_nx = (code >= RISE_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_nx;
  end
endmodule

// File: rtl/swd_beat_sync.sv
module swd_beat_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  output logic beat_fall
);
  // SYNC_N synchroniser stages plus one stage for edge history
  logic [SYNC_N:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_N-1:0], beat};
  end

  assign beat_fall = pipe_q[SYNC_N] & ~pipe_q[SYNC_N-1];
endmodule

// File: rtl/swd_ramp_ctrl.sv
module swd_ramp_ctrl
  import swd_pkg::*;
#(
  parameter int unsigned CAP_TOP   = 100,
  parameter int unsigned CAP_FLOOR = 20,
  parameter int unsigned CHG_STEP  = 5,
  parameter int unsigned DIS_STEP  = 1,
  localparam int unsigned CAP_W    = $clog2(CAP_TOP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_ok_nx,
  input  logic             force_rst,
  input  logic             inhibit,
  input  logic             beat_fall,
  output phase_t           ph_nx,
  output logic [CAP_W-1:0] cap_q
);
  localparam logic [CAP_W-1:0] TOP_C   = CAP_W'(CAP_TOP);
  localparam logic [CAP_W-1:0] FLOOR_C = CAP_W'(CAP_FLOOR);

  phase_t           ph_q;
  logic [CAP_W-1:0] cap_nx;
  logic [CAP_W-1:0] up_v;
  logic [CAP_W-1:0] dn_v;
  logic             hit_top;    // charging step lands on the top limit
  logic             hit_floor;  // discharging step lands on the floor

  assign up_v      = CAP_W'(ramp_up(32'(cap_q), CHG_STEP, CAP_TOP));
  assign dn_v      = CAP_W'(ramp_down(32'(cap_q), DIS_STEP, CAP_FLOOR));
  assign hit_top   = (up_v == TOP_C);
  assign hit_floor = (dn_v == FLOOR_C);

  always_comb begin
    ph_nx  = ph_q;
    cap_nx = cap_q;
    if (!sup_ok_nx) begin
      ph_nx  = PH_OFF;
      cap_nx = '0;
    end else if (force_rst) begin
      ph_nx  = PH_HOLD;
      cap_nx = '0;
    end else begin
      unique case (ph_q)
        PH_OFF: ph_nx = PH_HOLD;
        PH_HOLD, PH_BITE: begin
          cap_nx = up_v;
          if (hit_top) ph_nx = PH_DRAIN;
        end
        PH_DRAIN: begin
          if (!inhibit) begin
            if (beat_fall) begin
              ph_nx = PH_FILL;
            end else begin
              cap_nx = dn_v;
              if (hit_floor) ph_nx = PH_BITE;
            end
          end
        end
        PH_FILL: begin
          if (!inhibit) begin
            cap_nx = up_v;
            if (hit_top) ph_nx = PH_DRAIN;
          end
        end
        default: begin
          ph_nx  = PH_OFF;
          cap_nx = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_OFF;
      cap_q <= '0;
    end else begin
      ph_q  <= ph_nx;
      cap_q <= cap_nx;
    end
  end
endmodule

// File: rtl/supply_watchdog_sup.sv
module supply_watchdog_sup
  import swd_pkg::*;
#(
  parameter int unsigned SUP_W     = 8,
  parameter int unsigned RISE_CODE = 172,
  parameter int unsigned FALL_CODE = 168,
  parameter int unsigned CAP_TOP   = 100,
  parameter int unsigned CAP_FLOOR = 20,
  parameter int unsigned CHG_STEP  = 5,
  parameter int unsigned DIS_STEP  = 1,
  parameter int unsigned SYNC_N    = 2,
  localparam int unsigned CAP_W    = $clog2(CAP_TOP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply_code,
  input  logic             heartbeat,
  input  logic             force_rst,
  input  logic             wd_inhibit,
  output logic             rst_hi,
  output logic             rst_lo
);
  logic             sup_ok_nx;
  logic             sup_ok_q;
  logic             beat_fall;
  phase_t           ph_nx;
  logic [CAP_W-1:0] cap_q;
  logic             hold_nx;   // reset requested after this edge
  logic             rst_hi_q;
  logic             rst_lo_q;

  swd_level_det #(
    .SUP_W(SUP_W), .RISE_CODE(RISE_CODE), .FALL_CODE(FALL_CODE)
  ) u_level (
    .clk(clk), .rst_n(rst_n), .code(supply_code),
    .ok_nx(sup_ok_nx), .ok_q(sup_ok_q)
  );

  swd_beat_sync #(.SYNC_N(SYNC_N)) u_beat (
    .clk(clk), .rst_n(rst_n), .beat(heartbeat), .beat_fall(beat_fall)
  );

  swd_ramp_ctrl #(
    .CAP_TOP(CAP_TOP), .CAP_FLOOR(CAP_FLOOR),
    .CHG_STEP(CHG_STEP), .DIS_STEP(DIS_STEP)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .sup_ok_nx(sup_ok_nx),
    .force_rst(force_rst), .inhibit(wd_inhibit), .beat_fall(beat_fall),
    .ph_nx(ph_nx), .cap_q(cap_q)
  );

  assign hold_nx = phase_in_reset(ph_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_hi_q <= 1'b1;
      rst_lo_q <= 1'b0;
    end else begin
      rst_hi_q <= hold_nx;
      rst_lo_q <= ~hold_nx;
    end
  end

  assign rst_hi = rst_hi_q;
  assign rst_lo = rst_lo_q;
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int unsigned SUP_W     = 8,
  parameter int unsigned RISE_CODE = 172,
  parameter int unsigned FALL_CODE = 168,
  parameter int unsigned CAP_TOP   = 100,
  localparam int unsigned CAP_W    = $clog2(CAP_TOP + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SUP_W-1:0] code,
  input logic             force_rst,
  input logic             wd_inhibit,
  input logic             rst_hi,
  input logic             rst_lo,
  input logic             sup_ok,
  input logic [CAP_W-1:0] cap
);
  localparam logic [SUP_W-1:0] RISE_C = SUP_W'(RISE_CODE);
  localparam logic [SUP_W-1:0] FALL_C = SUP_W'(FALL_CODE);
  localparam logic [CAP_W-1:0] TOP_C  = CAP_W'(CAP_TOP);

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hi != rst_lo);  // R1

  AST_BAND_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_ok && code < RISE_C) |=> rst_hi);  // R2

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (code < FALL_C) |=> (rst_hi && cap == '0));  // R3

  AST_RELEASE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_hi) |-> (cap == TOP_C));  // R4

  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cap <= TOP_C);  // R5

  AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_inhibit && !rst_hi && !force_rst && code >= FALL_C)
      |=> (!rst_hi && $stable(cap)));  // R7

  AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |=> (rst_hi && cap == '0));  // R8
endmodule

bind supply_watchdog_sup swd_checker #(
  .SUP_W(SUP_W), .RISE_CODE(RISE_CODE), .FALL_CODE(FALL_CODE), .CAP_TOP(CAP_TOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .code(supply_code), .force_rst(force_rst),
  .wd_inhibit(wd_inhibit), .rst_hi(rst_hi), .rst_lo(rst_lo),
  .sup_ok(sup_ok_q), .cap(cap_q)
);

// File: tb/sim_supply_watchdog_sup.sv
module sim_supply_watchdog_sup;
  localparam int RISE = 172, FALL = 168, TOP = 100, FLOOR = 20, CHG = 5, DIS = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code = 8'd0;
  logic       hb = 1'b1;
  logic       frc = 1'b0;
  logic       inh = 1'b0;
  logic       rst_hi, rst_lo;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  supply_watchdog_sup u0 (
    .clk(clk), .rst_n(rst_n), .supply_code(code), .heartbeat(hb),
    .force_rst(frc), .wd_inhibit(inh), .rst_hi(rst_hi), .rst_lo(rst_lo)
  );

  // Behavioural reference: mode names as integers, capacitor as an integer level
  int m_mode;   // 0 off, 1 hold, 2 drain, 3 fill, 4 bite
  int m_lvl;
  bit m_good;
  bit m_exp;
  int hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_lvl = 0; m_good = 0; m_exp = 1;
      hist = '{0, 0, 0};
    end else begin
      bit good, fell;
      good = m_good ? (int'(code) >= FALL) : (int'(code) >= RISE);
      fell = (hist[0] == 1) && (hist[1] == 0);   // oldest two stages
      hist.pop_front();
      hist.push_back(int'(hb));
      m_good = good;
      if (!good) begin m_mode = 0; m_lvl = 0; end
      else if (frc) begin m_mode = 1; m_lvl = 0; end
      else if (m_mode == 0) m_mode = 1;
      else if (m_mode == 1 || m_mode == 4) begin
        m_lvl = (m_lvl + CHG > TOP) ? TOP : m_lvl + CHG;
        if (m_lvl == TOP) m_mode = 2;
      end else if (m_mode == 2 && !inh) begin
        if (fell) m_mode = 3;
        else begin
          m_lvl = (m_lvl - DIS < FLOOR) ? FLOOR : m_lvl - DIS;
          if (m_lvl == FLOOR) m_mode = 4;
        end
      end else if (m_mode == 3 && !inh) begin
        m_lvl = (m_lvl + CHG > TOP) ? TOP : m_lvl + CHG;
        if (m_lvl == TOP) m_mode = 2;
      end
      m_exp = !(m_mode == 2 || m_mode == 3);
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the reference on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk({cur_req, " rst_hi vs model"}, rst_hi === m_exp, int'(rst_hi), int'(m_exp));
      chk("R1 complement", rst_lo === ~rst_hi, int'(rst_lo), int'(~rst_hi));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_hb();
    hb = 1'b0; cycles(2); hb = 1'b1;
  endtask

  // Count edges until rst_hi reaches the wanted level
  task automatic measure(input bit want, input bit toggle, output int n);
    n = 0;
    while (rst_hi !== want && n < 2000) begin
      @(negedge clk);
      if (toggle) hb = ~hb;
      n++;
    end
    hb = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    int n;
    cycles(4);
    chk("R1 reset value rst_hi", rst_hi === 1'b1, int'(rst_hi), 1);
    chk("R1 reset value rst_lo", rst_lo === 1'b0, int'(rst_lo), 0);
    rst_n = 1'b1;

    cur_req = "R2"; cycles(8);
    code = 8'd170; cycles(10);               // inside band from below: stays in reset
    chk("R2 band from below", rst_hi === 1'b1, int'(rst_hi), 1);

    cur_req = "R4"; code = 8'd180;
    measure(1'b0, 1'b0, n);
    chk("R4 supply hold edges", n == TOP / CHG + 1, n, TOP / CHG + 1);

    cur_req = "R5";
    measure(1'b1, 1'b0, n);
    chk("R5 drain edges", n == (TOP - FLOOR) / DIS, n, (TOP - FLOOR) / DIS);
    measure(1'b0, 1'b0, n);
    chk("R5 refill edges", n == (TOP - FLOOR) / CHG, n, (TOP - FLOOR) / CHG);

    cur_req = "R6";
    for (int k = 0; k < 8; k++) begin cycles(28); pulse_hb(); end
    chk("R6 fed watchdog stays released", rst_hi === 1'b0, int'(rst_hi), 0);

    cur_req = "R7"; inh = 1'b1; cycles(150);
    chk("R7 inhibited no bite", rst_hi === 1'b0, int'(rst_hi), 0);

    cur_req = "R3"; code = 8'd150; cycles(1);
    chk("R3 drop while inhibited", rst_hi === 1'b1, int'(rst_hi), 1);
    cycles(2);

    cur_req = "R4"; code = 8'd180;
    measure(1'b0, 1'b1, n);                  // heartbeat toggles every cycle in hold
    chk("R4 hold ignores heartbeat", n == TOP / CHG + 1, n, TOP / CHG + 1);
    inh = 1'b0;

    cur_req = "R6"; cycles(10); pulse_hb(); cycles(10);

    cur_req = "R8"; frc = 1'b1; cycles(5);
    chk("R8 forced reset active", rst_hi === 1'b1, int'(rst_hi), 1);
    frc = 1'b0;
    measure(1'b0, 1'b0, n);
    chk("R8 forced hold edges", n == TOP / CHG, n, TOP / CHG);

    cur_req = "R2"; code = 8'd169;           // inside band from above: stays released
    for (int k = 0; k < 3; k++) begin cycles(20); pulse_hb(); end
    chk("R2 band from above", rst_hi === 1'b0, int'(rst_hi), 0);

    cur_req = "R3"; code = 8'd160; cycles(1);
    chk("R3 drop asserts reset", rst_hi === 1'b1, int'(rst_hi), 1);
    cycles(5);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule